// File: doc/BRIEF.md
# Four-Channel Wiper Position Register Bank

This block holds the settings of four digitally controlled potentiometer channels. Each channel owns one volatile 6-bit wiper position and four 6-bit data registers that stand in for nonvolatile storage. The wiper position is decoded onto a one-hot bank of 64 tap-select lines per channel, which would drive the switches of a resistor ladder.

A host issues one command per cycle on a command port: channel, register index, operation and a 6-bit operand. The operations are:

- set the wiper directly;
- copy a data register into the wiper;
- step the wiper up or down by one;
- read a data register;
- write a data register;
- store the wiper into a data register.

Any change to a data register starts a timed storage write. The busy flag shows that write for a parameterized number of cycles.

The command port has a valid/ready pair, and ready is always high, so the block never applies back-pressure. A command that cannot be carried out while busy is not stalled. It is dropped, and a one-cycle reject pulse is raised. Read results appear as a one-cycle strobe with no ready; the consumer must take the value in that cycle. A power-on reset initializes all storage. A soft reset keeps the data registers and reloads every wiper from data register 0 of its own channel.

Top module: `wb_bank`

## Requirements
- R1: While `por_n` is low, all data registers and all wipers take `DR_DEFAULT` (0), and busy, reject and `rd_valid` are low. While `rst_n` is low with `por_n` high, each wiper loads data register 0 of its channel, the data registers keep their contents, and busy is cleared. No command is accepted while either reset is low.
- R2: For every channel c with wiper value w, `tap_sel[c*64 + w]` is the only high line in the slice `tap_sel[c*64 +: 64]`.
- R3: Operation code 0 loads the selected channel's wiper with `cmd_data[5:0]`. Other channels are unchanged.
- R4: Operation code 1 loads the selected channel's wiper from its data register `cmd_reg`.
- R5: Operation code 2 raises the wiper by one and code 3 lowers it by one. An increment at 63 or a decrement at 0 leaves the wiper unchanged.
- R6: Operation code 5 writes `cmd_data` into data register `cmd_reg` of channel `cmd_chan`. Operation code 4 reads that register: `rd_valid` is high for exactly the cycle after the command edge, and `rd_data` holds the value. A read issued while that register's write is still timing out returns the new value.
- R7: Operation code 6 stores the channel's current wiper value into data register `cmd_reg`.
- R8: An accepted code 5 or code 6 command holds `busy` high for exactly `NV_CYCLES` cycles, starting in the cycle after the command edge.
- R9: While `busy` is high, code 5 and code 6 commands are dropped and `reject` pulses high for one cycle. Codes 0 to 4 still execute and raise no reject.
- R10: `cmd_ready` is always high. Operation code 7 changes no register and raises neither `rd_valid`, `reject` nor `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, synchronous, active low; initializes storage |
| rst_n | input | 1 | Soft reset, synchronous, active low; wipers reload from data register 0 |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always high; commands are never stalled |
| cmd_op | input | 3 | Operation code (0 set, 1 copy, 2 up, 3 down, 4 read, 5 write, 6 store, 7 none) |
| cmd_chan | input | 2 | Channel index |
| cmd_reg | input | 2 | Data register index |
| cmd_data | input | 6 | Operand for set and write |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 6 | Read result |
| busy | output | 1 | Storage write in progress |
| reject | output | 1 | One-cycle pulse for a command dropped while busy |
| tap_sel | output | 256 | One-hot tap selects, 64 per channel, channel 0 in the low bits |

## Verification
On every cycle the assertions check the following:

- each channel's tap slice stays one-hot;
- a storage-changing command while busy yields a reject, and every reject traces back to such a command;
- every read command yields a strobe, and every strobe traces back to a read command;
- an accepted storage write raises busy, and busy never runs longer than the write time;
- the wiper holds at either end under further steps.

Only the bench scenarios can show the data contents:

- the exact busy length;
- which value a register holds after a write or a dropped write;
- the value a read returns while the write is still timing out;
- the soft reset reloading each wiper from the data register 0 of its own channel while the data is preserved.

// File: rtl/wb_pkg.sv
package wb_pkg;

  typedef enum logic [2:0] {
    OP_WSET = 3'd0,
    OP_XFER = 3'd1,
    OP_INC  = 3'd2,
    OP_DEC  = 3'd3,
    OP_RD   = 3'd4,
    OP_WR   = 3'd5,
    OP_SAVE = 3'd6,
    OP_NONE = 3'd7
  } wb_op_e;

  // Operations that modify a data register and therefore start a storage write
  function automatic logic is_nv(wb_op_e op);
    return (op == OP_WR) || (op == OP_SAVE);
  endfunction

endpackage

// File: rtl/wb_channel.sv
module wb_channel #(
  parameter int WB         = 6,
  parameter int NDR        = 4,
  parameter int DR_DEFAULT = 0,
  localparam int RB        = $clog2(NDR)
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               rst_n,
  input  logic               en,
  input  wb_pkg::wb_op_e     op,
  input  logic [RB-1:0]      sel_reg,
  input  logic [WB-1:0]      din,
  output logic [WB-1:0]      wiper,
  output logic [WB-1:0]      dr_sel
);
  import wb_pkg::*;

  localparam logic [WB-1:0] WMAX = '1;
  localparam logic [WB-1:0] WDEF = WB'(DR_DEFAULT);

  logic [WB-1:0] dr [NDR];
  logic [WB-1:0] wiper_q;

  // Storage registers: only power-on reset clears them
  for (genvar i = 0; i < NDR; i++) begin : g_dr
    always_ff @(posedge clk) begin
      if (!por_n)
        dr[i] <= WDEF;
      else if (rst_n && en && is_nv(op) && (sel_reg == RB'(i)))
        dr[i] <= (op == OP_WR) ? din : wiper_q;
    end
  end

  // Wiper: four load paths plus restore from register 0
  always_ff @(posedge clk) begin
    if (!por_n)
      wiper_q <= WDEF;
    else if (!rst_n)
      wiper_q <= dr[0];
    else if (en) begin
      case (op)
        OP_WSET: wiper_q <= din;
        OP_XFER: wiper_q <= dr[sel_reg];
        OP_INC:  if (wiper_q != WMAX) wiper_q <= wiper_q + WB'(1);
        OP_DEC:  if (wiper_q != '0)   wiper_q <= wiper_q - WB'(1);
        default: ;
      endcase
    end
  end

  assign wiper  = wiper_q;
  assign dr_sel = dr[sel_reg];

endmodule

// File: rtl/wb_nvtimer.sv
module wb_nvtimer #(
  parameter int NV_CYCLES = 1000,
  localparam int CW       = $clog2(NV_CYCLES + 1)
) (
  input  logic clk,
  input  logic clr,
  input  logic start,
  output logic busy
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (clr)
      cnt <= '0;
    else if (start)
      cnt <= CW'(NV_CYCLES);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/wb_tapdec.sv
module wb_tapdec #(
  parameter int WB   = 6,
  localparam int TAPS = 1 << WB
) (
  input  logic [WB-1:0]   pos,
  output logic [TAPS-1:0] taps
);
  always_comb begin
    taps      = '0;
    taps[pos] = 1'b1;
  end
endmodule

// File: rtl/wb_bank.sv
module wb_bank #(
  parameter int CHANS      = 4,
  parameter int WB         = 6,
  parameter int NDR        = 4,
  parameter int NV_CYCLES  = 1000,
  parameter int DR_DEFAULT = 0,
  localparam int CB        = $clog2(CHANS),
  localparam int RB        = $clog2(NDR),
  localparam int TAPS      = 1 << WB
) (
  input  logic                  clk,
  input  logic                  por_n,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic [2:0]            cmd_op,
  input  logic [CB-1:0]         cmd_chan,
  input  logic [RB-1:0]         cmd_reg,
  input  logic [WB-1:0]         cmd_data,
  output logic                  rd_valid,
  output logic [WB-1:0]         rd_data,
  output logic                  busy,
  output logic                  reject,
  output logic [CHANS*TAPS-1:0] tap_sel
);
  import wb_pkg::*;

  wb_op_e        op;
  logic          live, nv, accept, drop;
  logic [WB-1:0] chan_w  [CHANS];
  logic [WB-1:0] chan_dr [CHANS];

  assign op        = wb_op_e'(cmd_op);
  assign live      = por_n && rst_n;
  assign nv        = is_nv(op);
  assign accept    = cmd_valid && live && !(busy && nv);
  assign drop      = cmd_valid && live && busy && nv;
  assign cmd_ready = 1'b1;

  wb_nvtimer #(.NV_CYCLES(NV_CYCLES)) u_timer (
    .clk   (clk),
    .clr   (!live),
    .start (accept && nv),
    .busy  (busy)
  );

  for (genvar c = 0; c < CHANS; c++) begin : g_chan
    wb_channel #(.WB(WB), .NDR(NDR), .DR_DEFAULT(DR_DEFAULT)) u_ch (
      .clk     (clk),
      .por_n   (por_n),
      .rst_n   (rst_n),
      .en      (accept && (cmd_chan == CB'(c))),
      .op      (op),
      .sel_reg (cmd_reg),
      .din     (cmd_data),
      .wiper   (chan_w[c]),
      .dr_sel  (chan_dr[c])
    );

    wb_tapdec #(.WB(WB)) u_dec (
      .pos  (chan_w[c]),
      .taps (tap_sel[c*TAPS +: TAPS])
    );
  end

  always_ff @(posedge clk) begin
    if (!live) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      reject   <= 1'b0;
    end else begin
      rd_valid <= accept && (op == OP_RD);
      if (accept && (op == OP_RD))
        rd_data <= chan_dr[cmd_chan];
      reject   <= drop;
    end
  end

endmodule

// File: rtl/wb_bank_chk.sv
module wb_bank_chk #(
  parameter int CHANS     = 4,
  parameter int WB        = 6,
  parameter int NV_CYCLES = 1000,
  localparam int CB       = $clog2(CHANS),
  localparam int TAPS     = 1 << WB
) (
  input logic                  clk,
  input logic                  por_n,
  input logic                  rst_n,
  input logic                  cmd_valid,
  input logic [2:0]            cmd_op,
  input logic [CB-1:0]         cmd_chan,
  input logic                  busy,
  input logic                  reject,
  input logic                  rd_valid,
  input logic [CHANS*TAPS-1:0] tap_sel
);
  logic nv_cmd;
  int   run;

  assign nv_cmd = cmd_valid && ((cmd_op == 3'd5) || (cmd_op == 3'd6));

  always_ff @(posedge clk) begin
    if (!por_n || !rst_n) run <= 0;
    else                  run <= busy ? run + 1 : 0;
  end

  // R9
  reject_on_busy_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    nv_cmd && busy |=> reject);

  // R9
  reject_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    reject |-> $past(nv_cmd && busy));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    nv_cmd && !busy |=> busy);

  // R8
  busy_len_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    busy |-> run < NV_CYCLES);

  // R6
  read_strobe_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    cmd_valid && cmd_op == 3'd4 |=> rd_valid);

  // R6
  read_cause_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    rd_valid |-> $past(cmd_valid && cmd_op == 3'd4));

  for (genvar c = 0; c < CHANS; c++) begin : g_c
    // R2
    tap_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
      $countones(tap_sel[c*TAPS +: TAPS]) == 1);

    // R5
    top_sat_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      cmd_valid && cmd_chan == CB'(c) && cmd_op == 3'd2 && tap_sel[c*TAPS + TAPS - 1]
      |=> tap_sel[c*TAPS + TAPS - 1]);

    // R5
    bottom_sat_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      cmd_valid && cmd_chan == CB'(c) && cmd_op == 3'd3 && tap_sel[c*TAPS]
      |=> tap_sel[c*TAPS]);
  end

endmodule

bind wb_bank wb_bank_chk #(.CHANS(CHANS), .WB(WB), .NV_CYCLES(NV_CYCLES)) u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_chan  (cmd_chan),
  .busy      (busy),
  .reject    (reject),
  .rd_valid  (rd_valid),
  .tap_sel   (tap_sel)
);

// File: tb/wb_bank_test.sv
`timescale 1ns/1ps
module wb_bank_test;
  localparam int NV = 6;

  logic         clk = 1'b0;
  logic         por_n, rst_n, cmd_valid;
  logic [2:0]   cmd_op;
  logic [1:0]   cmd_chan, cmd_reg;
  logic [5:0]   cmd_data;
  logic         cmd_ready, rd_valid, busy, reject;
  logic [5:0]   rd_data;
  logic [255:0] tap_sel;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_w  [4];
  int exp_dr [4][4];

  always #2 clk = ~clk;

  wb_bank #(.NV_CYCLES(NV)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_chan(cmd_chan), .cmd_reg(cmd_reg), .cmd_data(cmd_data),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .reject(reject), .tap_sel(tap_sel)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int wpos(input int c);
    int hits = 0;
    int idx = -1;
    for (int i = 0; i < 64; i++)
      if (tap_sel[c*64 + i]) begin hits++; idx = i; end
    return (hits == 1) ? idx : -1;
  endfunction

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // Called at a negedge; returns at the negedge after the command edge
  task automatic cmd(input int op, input int ch, input int rg, input int d);
    cmd_op = 3'(op); cmd_chan = 2'(ch); cmd_reg = 2'(rg); cmd_data = 6'(d);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_chk(input int ch, input int rg, input string tag);
    cmd(4, ch, rg, 0);
    check(rd_valid === 1'b1 && int'(rd_data) == exp_dr[ch][rg], tag, int'(rd_data), exp_dr[ch][rg]);
  endtask

  task automatic wipers_chk(input string tag);
    for (int c = 0; c < 4; c++) check(wpos(c) == exp_w[c], tag, wpos(c), exp_w[c]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int n;
    por_n = 0; rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_chan = 0; cmd_reg = 0; cmd_data = 0;
    for (int c = 0; c < 4; c++) begin
      exp_w[c] = 0;
      for (int r = 0; r < 4; r++) exp_dr[c][r] = 0;
    end
    repeat (3) @(negedge clk);
    por_n = 1; rst_n = 1;
    @(negedge clk);

    // R1 reset state, R10 ready
    wipers_chk("R1 por wiper");
    check(busy == 0 && reject == 0 && rd_valid == 0, "R1 por flags", {busy, reject, rd_valid}, 0);
    check(cmd_ready == 1, "R10 ready", cmd_ready, 1);
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) read_chk(c, r, "R1 por data");

    // R6 and R8: write every register, time busy, read back
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        exp_dr[c][r] = (c*13 + r*7 + 5) % 64;
        cmd(5, c, r, exp_dr[c][r]);
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check(n == NV, "R8 busy length", n, NV);
        read_chk(c, r, "R6 write/read");
      end

    // R4 transfer from every register
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        cmd(1, c, r, 0);
        exp_w[c] = exp_dr[c][r];
        wipers_chk("R4 transfer");
      end

    // R3 and R2 direct set sweep over all positions on all channels
    for (int c = 0; c < 4; c++)
      for (int v = 0; v < 64; v++) begin
        cmd(0, c, 0, v);
        exp_w[c] = v;
        wipers_chk("R3 direct set");
      end

    // R5 stepping and saturation
    cmd(0, 1, 0, 61); exp_w[1] = 61;
    for (int k = 0; k < 4; k++) begin
      cmd(2, 1, 0, 0);
      exp_w[1] = (exp_w[1] < 63) ? exp_w[1] + 1 : 63;
      wipers_chk("R5 increment");
    end
    cmd(0, 2, 0, 2); exp_w[2] = 2;
    for (int k = 0; k < 4; k++) begin
      cmd(3, 2, 0, 0);
      exp_w[2] = (exp_w[2] > 0) ? exp_w[2] - 1 : 0;
      wipers_chk("R5 decrement");
    end

    // R7 store wiper into a register
    cmd(0, 3, 0, 42); exp_w[3] = 42;
    cmd(6, 3, 2, 0); exp_dr[3][2] = 42;
    check(busy == 1, "R7 store starts write", busy, 1);
    wait_idle();
    read_chk(3, 2, "R7 store readback");

    // R9 behaviour while busy
    cmd(5, 0, 1, 9); exp_dr[0][1] = 9;
    check(busy == 1 && reject == 0, "R9 first write accepted", {busy, reject}, 2);
    cmd(5, 0, 1, 50);
    check(reject == 1, "R9 write dropped", reject, 1);
    read_chk(0, 1, "R6 read during write returns new value");
    check(reject == 0, "R9 reject one cycle", reject, 0);
    cmd(6, 0, 3, 0);
    check(reject == 1, "R9 store dropped", reject, 1);
    check(busy == 1, "R9 still busy", busy, 1);
    cmd(0, 0, 0, 17); exp_w[0] = 17;
    check(reject == 0, "R9 set while busy no reject", reject, 0);
    wipers_chk("R9 set while busy");
    cmd(2, 0, 0, 0); exp_w[0] = 18;
    wipers_chk("R9 step while busy");
    wait_idle();
    read_chk(0, 1, "R9 dropped write left value");
    read_chk(0, 3, "R9 dropped store left value");

    // R10 null operation
    cmd(7, 1, 2, 33);
    check(rd_valid == 0 && reject == 0 && busy == 0, "R10 null flags", {rd_valid, reject, busy}, 0);
    wipers_chk("R10 null wiper");
    read_chk(1, 2, "R10 null data");

    // R1 soft reset: wipers reload register 0, data preserved
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) exp_w[c] = exp_dr[c][0];
    wipers_chk("R1 soft reset wiper");
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) read_chk(c, r, "R1 soft reset keeps data");

    // R1 power-on reset clears everything
    por_n = 0;
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      exp_w[c] = 0;
      for (int r = 0; r < 4; r++) exp_dr[c][r] = 0;
    end
    wipers_chk("R1 second por wiper");
    for (int c = 0; c < 4; c++) for (int r = 0; r < 4; r++) read_chk(c, r, "R1 second por data");

    finish_run();
  end
endmodule